// File: doc/BRIEF.md
# Weighted Fair Queue Packet Scheduler

This block keeps packet descriptors for a small fixed number of flows and decides which descriptor goes next onto a single output link. Every arriving descriptor names its flow and gives a packet length. On entry the block computes a virtual start tag and a virtual finish tag for it. It then appends the descriptor to that flow's FIFO. The block always offers, from among the non-empty flows, the head descriptor whose finish tag is earliest. A whole packet leaves as one grant.

A virtual clock (the round number) advances more slowly as more flows hold packets, so tags follow an idealised bit-by-bit round-robin share. Each flow has a fixed cost multiplier, set by parameter, that scales its packet length into virtual time. A flow with a smaller multiplier has a larger share of the link. All tags are modulo 2^TAG_W and are compared by wrap-safe subtraction.

The round-number keeper is a two-state machine. VC_IDLE is the state with no backlog: the round number holds and the cycle divider is cleared. VC_RUN is the state in which the divider counts. The transition START (VC_IDLE to VC_RUN) is taken at the edge that ends any cycle with at least one non-empty flow. The transition STOP (VC_RUN to VC_IDLE) is taken at the edge that ends a cycle in which every flow is empty.

Top module: `wfq_sched`

## Requirements
- R1: After reset out_valid is 0, round_num is 0, and in_ready is 1 for every flow.
- R2: An accepted descriptor whose flow FIFO is empty at the start of the arrival cycle gets a start tag equal to round_num in that cycle.
- R3: An accepted descriptor whose flow FIFO is non-empty at the start of the arrival cycle gets a start tag equal to the finish tag of the previous descriptor of that flow.
- R4: The finish tag equals the start tag plus in_len times the flow's cost multiplier, which is field [f*SCALE_W +: SCALE_W] of FLOW_SCALE. The sum is taken modulo 2^TAG_W.
- R5: out_valid is 1 exactly when at least one flow FIFO is non-empty. out_flow, out_len and out_finish then describe the head descriptor with the earliest finish tag. Tag a comes before tag b when bit TAG_W-1 of (a - b mod 2^TAG_W) is 1.
- R6: Among heads that come equally early, the lowest flow index is offered. The heads are scanned from index 0 upward, and a later head replaces the current choice only if it comes strictly before it.
- R7: When out_valid and out_ready are both 1, the offered descriptor is removed at that clock edge. Within one flow, descriptors leave in arrival order.
- R8: round_num holds while no flow is backlogged. It never steps by more than 1 per cycle. In VC_RUN, with k non-empty flows, it rises by 1 once every k cycles. The first backlogged cycle after VC_IDLE does not count.
- R9: in_ready is 0 while the FIFO of the flow named by in_flow holds DEPTH descriptors, and an arrival offered then is dropped.
- R10: While out_ready and in_valid stay 0, the offered flow and finish tag do not change.
- R11: Tags and round_num wrap modulo 2^TAG_W, and ordering across the wrap follows the rule of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_flow | input | FLOW_W | Flow index of the offered descriptor |
| in_len | input | LEN_W | Packet length |
| in_ready | output | 1 | Named flow FIFO has room |
| out_ready | input | 1 | Link takes the offered packet this cycle |
| out_valid | output | 1 | A descriptor is offered |
| out_flow | output | FLOW_W | Flow of the offered descriptor |
| out_len | output | LEN_W | Length of the offered descriptor |
| out_finish | output | TAG_W | Finish tag of the offered descriptor |
| round_num | output | TAG_W | Current round number |

## Verification
The bench builds the block with four flows, FIFO depth 4, 4-bit lengths and 8-bit tags. The cost multipliers are 2, 3, 3 and 6, which gives shares in the ratio 3:2:2:1. The narrow tag width makes the round number and the finish tags wrap after a few hundred cycles, so ordering across the wrap (R11) is exercised many times. The shallow FIFOs fill within a handful of cycles when the link is held off, which reaches the dropped-arrival case of R9. The unequal multipliers let equal lengths on different flows produce different finish tags, and let equal finish tags arise on flows 1 and 2, which share a multiplier (R4, R6).

// File: rtl/wfq_pkg.sv
package wfq_pkg;

    // States of the round-number keeper
    typedef enum logic {
        VC_IDLE = 1'b0,
        VC_RUN  = 1'b1
    } vc_state_e;

endpackage

// File: rtl/wfq_flow_fifo.sv
module wfq_flow_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LEN_W = 8,
    parameter int unsigned TAG_W = 16,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic [TAG_W-1:0] push_fin,
    input  logic             pop,
    output logic [LEN_W-1:0] head_len,
    output logic [TAG_W-1:0] head_fin,
    output logic             full,
    output logic             nonempty
);

    logic [LEN_W-1:0] len_mem [DEPTH];
    logic [TAG_W-1:0] fin_mem [DEPTH];
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    fill;

    logic do_pop;
    logic do_push;

    assign do_pop  = pop && (fill != '0);
    assign do_push = push && (fill != CW'(DEPTH));

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push) wr_ptr <= bump(wr_ptr);
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            len_mem[wr_ptr] <= push_len;
            fin_mem[wr_ptr] <= push_fin;
        end
    end

    assign head_len = len_mem[rd_ptr];
    assign head_fin = fin_mem[rd_ptr];
    assign full     = (fill == CW'(DEPTH));
    assign nonempty = (fill != '0);

endmodule

// File: rtl/wfq_vclock.sv
module wfq_vclock
    import wfq_pkg::*;
#(
    parameter int unsigned TAG_W = 16,
    parameter int unsigned ACT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACT_W-1:0] n_active,
    output logic [TAG_W-1:0] round_num
);

    vc_state_e        state_q, state_d;
    logic [ACT_W-1:0] div_q, div_d;
    logic [TAG_W-1:0] round_q, round_d;
    logic [ACT_W:0]   div_inc;

    assign div_inc = {1'b0, div_q} + {{ACT_W{1'b0}}, 1'b1};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VC_IDLE;
            div_q   <= '0;
            round_q <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= div_d;
            round_q <= round_d;
        end
    end

    // Next state and counters
    always_comb begin
        state_d = state_q;
        div_d   = div_q;
        round_d = round_q;
        unique case (state_q)
            VC_IDLE: begin
                div_d = '0;
                if (n_active != '0) state_d = VC_RUN;    // START
            end
            VC_RUN: begin
                if (n_active == '0) begin
                    state_d = VC_IDLE;                   // STOP
                    div_d   = '0;
                end else if (div_inc >= {1'b0, n_active}) begin
                    div_d   = '0;
                    round_d = round_q + TAG_W'(1);
                end else begin
                    div_d = div_inc[ACT_W-1:0];
                end
            end
            default: state_d = VC_IDLE;
        endcase
    end

    assign round_num = round_q;

endmodule

// File: rtl/wfq_min_select.sv
module wfq_min_select #(
    parameter int unsigned NFLOWS = 4,
    parameter int unsigned TAG_W  = 16,
    localparam int unsigned FLOW_W = (NFLOWS > 1) ? $clog2(NFLOWS) : 1
) (
    input  logic [NFLOWS-1:0]       cand,
    input  logic [NFLOWS*TAG_W-1:0] tags,
    output logic                    any,
    output logic [FLOW_W-1:0]       sel
);

    logic [TAG_W-1:0] best;
    logic [TAG_W-1:0] diff;

    // Scan upward; a later candidate wins only when strictly earlier
    always_comb begin
        any  = 1'b0;
        sel  = '0;
        best = '0;
        diff = '0;
        for (int i = 0; i < int'(NFLOWS); i++) begin
            if (cand[i]) begin
                diff = tags[i*TAG_W +: TAG_W] - best;
                if (!any || diff[TAG_W-1]) begin
                    any  = 1'b1;
                    sel  = FLOW_W'(i);
                    best = tags[i*TAG_W +: TAG_W];
                end
            end
        end
    end

endmodule

// File: rtl/wfq_sched.sv
module wfq_sched
    import wfq_pkg::*;
#(
    parameter int unsigned NFLOWS  = 4,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned TAG_W   = 16,
    parameter int unsigned SCALE_W = 4,
    parameter logic [NFLOWS*SCALE_W-1:0] FLOW_SCALE = {NFLOWS{SCALE_W'(1)}},
    localparam int unsigned FLOW_W = (NFLOWS > 1) ? $clog2(NFLOWS) : 1,
    localparam int unsigned ACT_W  = $clog2(NFLOWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [LEN_W-1:0]  in_len,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [FLOW_W-1:0] out_flow,
    output logic [LEN_W-1:0]  out_len,
    output logic [TAG_W-1:0]  out_finish,
    output logic [TAG_W-1:0]  round_num
);

    logic [NFLOWS-1:0]       ne;
    logic [NFLOWS-1:0]       full;
    logic [NFLOWS-1:0]       push_v;
    logic [NFLOWS-1:0]       pop_v;
    logic [LEN_W-1:0]        head_len [NFLOWS];
    logic [TAG_W-1:0]        head_fin [NFLOWS];
    logic [NFLOWS*TAG_W-1:0] head_fin_flat;
    logic [ACT_W-1:0]        n_active;
    logic                    accept;
    logic                    grant;

    assign in_ready = ~full[in_flow];
    assign accept   = in_valid && in_ready;
    assign grant    = out_valid && out_ready;
    assign n_active = ACT_W'($countones(ne));

    for (genvar g = 0; g < int'(NFLOWS); g++) begin : g_flow
        logic [TAG_W-1:0]         last_fin_q;
        logic [TAG_W-1:0]         start_tag;
        logic [TAG_W-1:0]         fin_tag;
        logic [LEN_W+SCALE_W-1:0] cost;

        assign cost      = in_len * FLOW_SCALE[g*SCALE_W +: SCALE_W];
        assign start_tag = ne[g] ? last_fin_q : round_num;
        assign fin_tag   = start_tag + TAG_W'(cost);
        assign push_v[g] = accept && (in_flow == FLOW_W'(g));
        assign pop_v[g]  = grant && (out_flow == FLOW_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n)        last_fin_q <= '0;
            else if (push_v[g]) last_fin_q <= fin_tag;
        end

        wfq_flow_fifo #(
            .DEPTH (DEPTH),
            .LEN_W (LEN_W),
            .TAG_W (TAG_W)
        ) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_v[g]),
            .push_len (in_len),
            .push_fin (fin_tag),
            .pop      (pop_v[g]),
            .head_len (head_len[g]),
            .head_fin (head_fin[g]),
            .full     (full[g]),
            .nonempty (ne[g])
        );

        assign head_fin_flat[g*TAG_W +: TAG_W] = head_fin[g];
    end

    wfq_min_select #(
        .NFLOWS (NFLOWS),
        .TAG_W  (TAG_W)
    ) u_sel (
        .cand (ne),
        .tags (head_fin_flat),
        .any  (out_valid),
        .sel  (out_flow)
    );

    assign out_len    = head_len[out_flow];
    assign out_finish = head_fin[out_flow];

    wfq_vclock #(
        .TAG_W (TAG_W),
        .ACT_W (ACT_W)
    ) u_vclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_active  (n_active),
        .round_num (round_num)
    );

endmodule

// File: rtl/wfq_sched_chk.sv
module wfq_sched_chk #(
    parameter int unsigned TAG_W  = 16,
    parameter int unsigned FLOW_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_ready,
    input logic              out_valid,
    input logic [FLOW_W-1:0] out_flow,
    input logic [TAG_W-1:0]  out_finish,
    input logic [TAG_W-1:0]  round_num
);

    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (round_num == $past(round_num) || round_num == $past(round_num) + TAG_W'(1))); // R8

    AST_ROUND_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> $stable(round_num)); // R8

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !in_valid) |=> (out_valid && $stable(out_flow) && $stable(out_finish))); // R10

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !in_valid) |=> !out_valid); // R5

endmodule

bind wfq_sched wfq_sched_chk #(.TAG_W(TAG_W), .FLOW_W(FLOW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_flow   (out_flow),
    .out_finish (out_finish),
    .round_num  (round_num)
);

// File: tb/wfq_sched_test.sv
module wfq_sched_test;

    localparam int NF = 4;
    localparam int DEPTH = 4;
    localparam int LW = 4;
    localparam int TW = 8;
    localparam int SB = 4;
    localparam logic [NF*SB-1:0] SCALE = {4'd6, 4'd3, 4'd3, 4'd2};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_flow = '0;
    logic [LW-1:0] in_len = '0;
    logic          in_ready;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [1:0]    out_flow;
    logic [LW-1:0] out_len;
    logic [TW-1:0] out_finish;
    logic [TW-1:0] round_num;

    int n_checks = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    wfq_sched #(
        .NFLOWS(NF), .DEPTH(DEPTH), .LEN_W(LW), .TAG_W(TW),
        .SCALE_W(SB), .FLOW_SCALE(SCALE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flow(in_flow),
        .in_len(in_len), .in_ready(in_ready), .out_ready(out_ready),
        .out_valid(out_valid), .out_flow(out_flow), .out_len(out_len),
        .out_finish(out_finish), .round_num(round_num)
    );

    // Reference model state
    int            m_len [NF][DEPTH];
    logic [TW-1:0] m_fin [NF][DEPTH];
    int            m_cnt [NF];
    logic [TW-1:0] m_last [NF];
    logic [TW-1:0] m_v;
    int            m_div;
    bit            m_run;
    int            grants0;

    function automatic int scale_of(input int f);
        return int'(SCALE[f*SB +: SB]);
    endfunction

    function automatic bit earlier(input logic [TW-1:0] a, input logic [TW-1:0] b);
        logic [TW-1:0] d;
        d = a - b;
        return d[TW-1];
    endfunction

    function automatic int pick();
        int best;
        best = -1;
        for (int i = 0; i < NF; i++)
            if (m_cnt[i] > 0)
                if (best < 0 || earlier(m_fin[i][0], m_fin[best][0])) best = i;
        return best;
    endfunction

    function automatic bit model_empty();
        for (int i = 0; i < NF; i++) if (m_cnt[i] > 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NF; i++) begin
            m_cnt[i] = 0;
            m_last[i] = '0;
        end
        m_v = '0;
        m_div = 0;
        m_run = 1'b0;
        grants0 = 0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, advance model, wait for next negedge
    task automatic step(input bit v, input int f, input int l, input bit rdy);
        int sel;
        int n;
        int pre;
        logic [TW-1:0] st;
        in_valid = v;
        in_flow = 2'(f);
        in_len = LW'(l);
        out_ready = rdy;
        #1;
        sel = pick();
        check("R5", "out_valid", int'(out_valid), int'(sel >= 0));
        if (sel >= 0) begin
            check("R5 R6", "out_flow", int'(out_flow), sel);
            check("R7", "out_len", int'(out_len), m_len[sel][0]);
            check("R2 R3 R4 R11", "out_finish", int'(out_finish), int'(m_fin[sel][0]));
        end
        check("R8 R11", "round_num", int'(round_num), int'(m_v));
        check("R9", "in_ready", int'(in_ready), int'(m_cnt[f] < DEPTH));

        n = 0;
        for (int i = 0; i < NF; i++) if (m_cnt[i] > 0) n++;
        pre = m_cnt[f];
        if (rdy && sel >= 0) begin
            if (sel == 0) grants0++;
            for (int k = 0; k < DEPTH - 1; k++) begin
                m_len[sel][k] = m_len[sel][k+1];
                m_fin[sel][k] = m_fin[sel][k+1];
            end
            m_cnt[sel]--;
        end
        if (v && pre < DEPTH) begin
            st = (pre > 0) ? m_last[f] : m_v;
            m_len[f][m_cnt[f]] = l;
            m_fin[f][m_cnt[f]] = st + TW'(l * scale_of(f));
            m_last[f] = m_fin[f][m_cnt[f]];
            m_cnt[f]++;
        end
        if (!m_run) begin
            m_div = 0;
            m_run = (n > 0);
        end else if (n == 0) begin
            m_run = 1'b0;
            m_div = 0;
        end else if (m_div + 1 >= n) begin
            m_div = 0;
            m_v = m_v + TW'(1);
        end else begin
            m_div++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (!model_empty() && guard < 100) begin
            step(1'b0, 0, 0, 1'b1);
            guard++;
        end
    endtask

    initial begin : watchdog
        #2000000;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : stim
        logic [1:0] held;
        int seed;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "round_num", int'(round_num), 0);
        for (int f = 0; f < NF; f++) begin
            in_flow = 2'(f);
            #1;
            check("R1", "in_ready", int'(in_ready), 1);
        end
        @(negedge clk);

        // R6: flows 1 and 2 share a multiplier, equal lengths give a tie
        step(1'b1, 2, 2, 1'b0);
        step(1'b1, 1, 2, 1'b0);
        step(1'b0, 0, 0, 1'b0);
        check("R6", "tie winner", int'(out_flow), 1);

        // R10: no input, no ready: offer held
        step(1'b1, 3, 1, 1'b0);
        held = out_flow;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 0, 0, 1'b0);
            check("R10", "held out_flow", int'(out_flow), int'(held));
        end
        drain();

        // R3 R4: back-to-back packets on one flow chain their tags
        step(1'b1, 0, 3, 1'b0);
        step(1'b1, 0, 4, 1'b0);
        step(1'b1, 3, 1, 1'b0);
        drain();

        // R9: overfill flow 0 with link held off
        grants0 = 0;
        for (int k = 0; k < DEPTH + 2; k++) step(1'b1, 0, 1, 1'b0);
        drain();
        check("R9", "flow0 grants after overfill", grants0, DEPTH);

        // Random traffic, long enough to wrap the 8-bit tags (R11)
        seed = 7;
        void'($urandom(seed));
        for (int c = 0; c < 4000; c++) begin
            bit v;
            bit r;
            int f;
            int l;
            v = ($urandom % 100) < 55;
            f = int'($urandom % NF);
            l = 1 + int'($urandom % 4);
            if ((c / 300) % 3 == 2) r = ($urandom % 100) < 15;
            else r = ($urandom % 100) < 45;
            step(v, f, l, r);
        end
        drain();
        check("R8", "idle round holds", int'(round_num), int'(m_v));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule